// File: doc/BRIEF.md
# MII Nibble Receive Frame Checker

This block sits behind a media-independent interface receive port running in four-bit parallel mode. The receive clock is 2.5 MHz at 10 Mb/s and 25 MHz at 100 Mb/s. The block strips the preamble and the start-of-frame delimiter. It packs the incoming nibbles into bytes and streams those bytes out. It runs a 32-bit CRC over every whole byte of the frame. When receive-data-valid drops, it reports one frame-end strobe carrying good, CRC-error, runt and line-error flags.

A buffer-full input from the downstream store is sampled at the moment the delimiter is seen. If it is high, the whole frame is discarded and an 8-bit missed-frame counter advances. The counter raises an interrupt level once it reaches a threshold far below its wrap point.

The control is one four-state machine:
- `ST_IDLE` waits for receive-data-valid.
- `ST_PREAMBLE` consumes preamble nibbles.
- `ST_DATA` packs nibbles and runs the CRC.
- `ST_SKIP` swallows a frame that is dropped or malformed.

The transitions are:
- idle-to-preamble on a 0x5 nibble.
- idle-to-data or preamble-to-data on the 0xD delimiter nibble with the buffer not full.
- idle-to-skip or preamble-to-skip on the delimiter with the buffer full, or on any other nibble.
- data-to-idle, skip-to-idle and preamble-to-idle when receive-data-valid falls.

Top module: `mii_rx_frame_checker`

## Requirements
- R1: After reset, `byte_valid`, `frame_end`, all frame flags, `miss_count` and `miss_irq` are 0.
- R2: In the data phase, nibbles pair into bytes with the first nibble as bits 3:0 and the second as bits 7:4. `byte_valid` pulses for one cycle, the cycle after the second nibble is sampled, with the byte on `byte_data`.
- R3: Preamble nibbles (0x5) and the delimiter nibble 0xD are never emitted. The first emitted byte is formed from the two nibbles that follow 0xD.
- R4: The CRC presets to all ones and uses polynomial 0x04C11DB7, least significant bit of each byte first. After the last byte, including the four check bytes, the bit-reversed CRC register must equal 0xC704DD7B. Otherwise `frame_crc_err` is 1 at frame end. A frame whose check bytes are the complemented CRC of the preceding bytes, least significant byte first, passes.
- R5: A frame with fewer than 64 whole bytes, check bytes included, has `frame_runt`=1 and `frame_good`=0. A 64-byte frame is not a runt.
- R6: `rx_er` high on any nibble while `rx_dv` is high in the data phase sets `frame_rx_err` and clears `frame_good` for that frame.
- R7: A trailing odd nibble before `rx_dv` falls is ignored. It produces no byte and does not enter the CRC.
- R8: If `buf_full` is high when the delimiter nibble is sampled, no bytes and no frame end are produced for that frame, and `miss_count` rises by exactly 1. `buf_full` at any other time has no effect.
- R9: `miss_irq` goes to 1 on the same edge at which `miss_count` reaches 192. It stays 1 up to 255. The counter wraps from 255 to 0, which clears `miss_irq`.
- R10: `frame_end` pulses for one cycle, exactly one cycle after the cycle in which `rx_dv` is sampled low in the data phase. The four flags are 0 outside that pulse. `frame_good` is 1 exactly when none of the other three flags is set.
- R11: A nibble other than 0x5 or 0xD before the delimiter discards the frame silently. No bytes and no frame end are produced, and the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the PHY |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error from the PHY |
| rxd | input | 4 | Receive nibble |
| buf_full | input | 1 | Downstream store cannot take a new frame |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Assembled frame byte |
| frame_end | output | 1 | One-cycle frame-end strobe |
| frame_good | output | 1 | Frame passed every check |
| frame_crc_err | output | 1 | CRC residue mismatch |
| frame_runt | output | 1 | Frame shorter than the minimum |
| frame_rx_err | output | 1 | PHY reported an error inside the frame |
| miss_count | output | 8 | Frames dropped because the buffer was full |
| miss_irq | output | 1 | Missed-frame count at or above the threshold |

## Verification
Frames of several lengths with correct check bytes are sent, including the exact minimum and one byte short of it. This separates the runt rule from the CRC rule. Single-bit corruption, a `rx_er` pulse, and an extra odd nibble after the check bytes each change one flag, or none, and so tell the CRC, line-error and whole-byte rules apart. Frames with buffer-full at the delimiter, buffer-full mid-frame and a broken preamble separate counted drops from ignored stimulus and silent discards. A long run of dropped frames walks the counter through the threshold and across the wrap.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_DATA,
        ST_SKIP
    } rx_state_e;

    localparam logic [3:0] NIB_PRE = 4'h5;
    localparam logic [3:0] NIB_SFD = 4'hD;

    function automatic logic [31:0] bit_rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            r[i] = v[31-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/rxfc_crc32.sv
module rxfc_crc32 #(
    parameter logic [31:0] POLY    = 32'h04C11DB7,
    parameter logic [31:0] RESIDUE = 32'hC704DD7B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic       match
);
    import rxfc_pkg::*;

    localparam logic [31:0] POLY_LSB = bit_rev32(POLY);

    logic [31:0] crc_q;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ POLY_LSB;
            else             r = r >> 1;
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc_q <= '1;
        else if (en)       crc_q <= crc_step(crc_q, din);
    end

    assign match = (bit_rev32(crc_q) == RESIDUE);

endmodule

// File: rtl/rxfc_nibble_pack.sv
module rxfc_nibble_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [3:0] nib,
    output logic       byte_stb,
    output logic [7:0] byte_out
);
    logic       phase_q;
    logic [3:0] lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= 1'b0;
            lo_q    <= '0;
        end else if (en) begin
            if (!phase_q) lo_q <= nib;
            phase_q <= ~phase_q;
        end
    end

    assign byte_stb = en && phase_q;
    assign byte_out = {nib, lo_q};

    // R2: a byte completes only one nibble after a first-half nibble was taken
    p_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> $past(en && !phase_q));

endmodule

// File: rtl/rxfc_miss_ctr.sv
module rxfc_miss_ctr #(
    parameter int CNT_W  = 8,
    parameter int THRESH = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam logic [CNT_W-1:0] THRESH_V = CNT_W'(THRESH);

    logic [CNT_W-1:0] cnt_next;

    assign cnt_next = count + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            irq   <= 1'b0;
        end else if (inc) begin
            count <= cnt_next;
            irq   <= (cnt_next >= THRESH_V);
        end
    end

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> (count == $past(count) + CNT_W'(1)));

    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (count == THRESH_V));

    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> (count == '0));

endmodule

// File: rtl/mii_rx_frame_checker.sv
module mii_rx_frame_checker #(
    parameter int          MIN_FRAME   = 64,
    parameter int          MISS_W      = 8,
    parameter int          MISS_IRQ_AT = 192,
    parameter logic [31:0] CRC_POLY    = 32'h04C11DB7,
    parameter logic [31:0] CRC_RESIDUE = 32'hC704DD7B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_dv,
    input  logic              rx_er,
    input  logic [3:0]        rxd,
    input  logic              buf_full,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic              frame_end,
    output logic              frame_good,
    output logic              frame_crc_err,
    output logic              frame_runt,
    output logic              frame_rx_err,
    output logic [MISS_W-1:0] miss_count,
    output logic              miss_irq
);
    import rxfc_pkg::*;

    localparam int             BC_W  = $clog2(MIN_FRAME + 1);
    localparam logic [BC_W-1:0] MIN_V = BC_W'(MIN_FRAME);

    rx_state_e       state_q, state_d;
    logic            in_data;
    logic            pack_en;
    logic            byte_stb;
    logic [7:0]      byte_out;
    logic            crc_ok;
    logic [BC_W-1:0] byte_cnt_q;
    logic            err_seen_q;
    logic            sfd_seen;
    logic            miss_inc;
    logic            ending;

    assign in_data  = (state_q == ST_DATA);
    assign pack_en  = in_data && rx_dv;
    assign ending   = in_data && !rx_dv;
    assign sfd_seen = rx_dv && (rxd == NIB_SFD) &&
                      ((state_q == ST_IDLE) || (state_q == ST_PREAMBLE));
    assign miss_inc = sfd_seen && buf_full;

    rxfc_nibble_pack u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!in_data),
        .en       (pack_en),
        .nib      (rxd),
        .byte_stb (byte_stb),
        .byte_out (byte_out)
    );

    rxfc_crc32 #(
        .POLY    (CRC_POLY),
        .RESIDUE (CRC_RESIDUE)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_data),
        .en    (byte_stb),
        .din   (byte_out),
        .match (crc_ok)
    );

    rxfc_miss_ctr #(
        .CNT_W  (MISS_W),
        .THRESH (MISS_IRQ_AT)
    ) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (miss_inc),
        .count (miss_count),
        .irq   (miss_irq)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_PREAMBLE: begin
                if (!rx_dv)               state_d = ST_IDLE;
                else if (rxd == NIB_SFD)  state_d = buf_full ? ST_SKIP : ST_DATA;
                else if (rxd == NIB_PRE)  state_d = ST_PREAMBLE;
                else                      state_d = ST_SKIP;
            end
            ST_DATA: if (!rx_dv) state_d = ST_IDLE;
            ST_SKIP: if (!rx_dv) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and per-frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt_q    <= '0;
            err_seen_q    <= 1'b0;
            byte_valid    <= 1'b0;
            byte_data     <= '0;
            frame_end     <= 1'b0;
            frame_good    <= 1'b0;
            frame_crc_err <= 1'b0;
            frame_runt    <= 1'b0;
            frame_rx_err  <= 1'b0;
        end else begin
            if (!in_data) begin
                byte_cnt_q <= '0;
                err_seen_q <= 1'b0;
            end else begin
                if (byte_stb && (byte_cnt_q < MIN_V)) byte_cnt_q <= byte_cnt_q + BC_W'(1);
                if (rx_dv && rx_er) err_seen_q <= 1'b1;
            end

            byte_valid <= byte_stb;
            if (byte_stb) byte_data <= byte_out;

            frame_end     <= ending;
            frame_runt    <= ending && (byte_cnt_q < MIN_V);
            frame_crc_err <= ending && !crc_ok;
            frame_rx_err  <= ending && err_seen_q;
            frame_good    <= ending && (byte_cnt_q >= MIN_V) && crc_ok && !err_seen_q;
        end
    end

    p_end_after_dv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !rx_dv) |=> frame_end);

    p_flags_split_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (frame_good != (frame_runt || frame_crc_err || frame_rx_err)));

    p_flags_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |-> !(frame_good || frame_runt || frame_crc_err || frame_rx_err));

    p_skip_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |=> !(byte_valid || frame_end));

    p_good_not_runt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && frame_good) |-> !frame_runt);

endmodule

// File: tb/mii_rx_frame_checker_bench.sv
module mii_rx_frame_checker_bench;

    localparam int CLK_PERIOD = 40;
    localparam int MIN_LEN    = 64;

    typedef struct packed {
        logic runt;
        logic crc;
        logic err;
        logic good;
    } res_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_dv = 1'b0;
    logic       rx_er = 1'b0;
    logic [3:0] rxd = '0;
    logic       buf_full = 1'b0;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       frame_end, frame_good, frame_crc_err, frame_runt, frame_rx_err;
    logic [7:0] miss_count;
    logic       miss_irq;

    logic [7:0] exp_bytes[$];
    res_t       exp_res[$];
    int         checks = 0;
    int         fails = 0;
    int         exp_cnt = 0;
    string      cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    mii_rx_frame_checker u_mii_rx_frame_checker (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
        .buf_full(buf_full), .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_end(frame_end), .frame_good(frame_good), .frame_crc_err(frame_crc_err),
        .frame_runt(frame_runt), .frame_rx_err(frame_rx_err),
        .miss_count(miss_count), .miss_irq(miss_irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                if (exp_bytes.size() == 0) check(1'b0, cur_req, "unexpected byte", byte_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_bytes.pop_front();
                    check(byte_data == e, cur_req, "byte (R2)", byte_data, e);
                end
            end
            if (frame_end) begin
                if (exp_res.size() == 0) check(1'b0, cur_req, "unexpected frame_end", 1, 0);
                else begin
                    res_t e, a;
                    e = exp_res.pop_front();
                    a = '{runt: frame_runt, crc: frame_crc_err, err: frame_rx_err, good: frame_good};
                    check(a == e, cur_req, "flags{runt,crc,err,good}", a, e);
                end
            end
        end
    end

    task automatic drive_nib(input logic [3:0] n, input logic er);
        @(negedge clk);
        rx_dv = 1'b1;
        rxd   = n;
        rx_er = er;
    endtask

    task automatic end_frame(input bit expect_end, input int idle);
        @(negedge clk);
        rx_dv = 1'b0;
        rxd   = '0;
        rx_er = 1'b0;
        @(negedge clk);
        check(frame_end == expect_end, "R10", "frame_end timing", frame_end, expect_end);
        repeat (idle) @(negedge clk);
    endtask

    task automatic preamble(input int n);
        for (int i = 0; i < n; i++) drive_nib(4'h5, 1'b0);
        drive_nib(4'hD, 1'b0);
    endtask

    task automatic send_frame(input int plen, input bit corrupt, input int er_nib,
                              input bit extra_nib, input bit mid_full);
        logic [7:0]  fb[$];
        logic [31:0] c = '1;
        res_t        r;
        for (int i = 0; i < plen; i++) begin
            logic [7:0] b;
            b = 8'((i * 37 + plen) & 255);
            fb.push_back(b);
            c = crc_upd(c, b);
        end
        c = ~c;
        for (int k = 0; k < 4; k++) fb.push_back(c[8*k +: 8]);
        if (corrupt) fb[2] = fb[2] ^ 8'h04;
        foreach (fb[i]) exp_bytes.push_back(fb[i]);
        r.runt = (fb.size() < MIN_LEN);
        r.crc  = corrupt;
        r.err  = (er_nib >= 0);
        r.good = !(r.runt || r.crc || r.err);
        exp_res.push_back(r);
        preamble(15);
        foreach (fb[i]) begin
            if (mid_full && i == 3) buf_full = 1'b1;
            drive_nib(fb[i][3:0], (2*i == er_nib));
            drive_nib(fb[i][7:4], (2*i+1 == er_nib));
        end
        if (extra_nib) drive_nib(4'hA, 1'b0);
        end_frame(1'b1, 3);
        buf_full = 1'b0;
        check(exp_bytes.size() == 0 && exp_res.size() == 0, cur_req, "missing outputs",
              exp_bytes.size() + exp_res.size(), 0);
    endtask

    task automatic drop_frame(input int pre_n, input int idle);
        buf_full = 1'b1;
        preamble(pre_n);
        drive_nib(4'h3, 1'b0);
        drive_nib(4'hC, 1'b0);
        end_frame(1'b0, idle);
        buf_full = 1'b0;
        exp_cnt = (exp_cnt + 1) % 256;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        repeat (5) @(negedge clk);
        cur_req = "R1";
        check({byte_valid, frame_end, frame_good, frame_crc_err, frame_runt, frame_rx_err, miss_irq} == 0,
              "R1", "reset outputs", {byte_valid, frame_end, miss_irq}, 0);
        check(miss_count == 0, "R1", "reset miss_count", miss_count, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R3"; send_frame(60, 1'b0, -1, 1'b0, 1'b0);   // 64 bytes, good; R4, R5
        cur_req = "R4"; send_frame(100, 1'b0, -1, 1'b0, 1'b0);  // longer good frame
        cur_req = "R4"; send_frame(70, 1'b1, -1, 1'b0, 1'b0);   // corrupted -> crc error
        cur_req = "R5"; send_frame(59, 1'b0, -1, 1'b0, 1'b0);   // 63 bytes -> runt
        cur_req = "R5"; send_frame(10, 1'b0, -1, 1'b0, 1'b0);   // short runt
        cur_req = "R6"; send_frame(64, 1'b0, 21, 1'b0, 1'b0);   // rx_er mid frame
        cur_req = "R7"; send_frame(64, 1'b0, -1, 1'b1, 1'b0);   // trailing nibble ignored
        cur_req = "R8"; send_frame(66, 1'b0, -1, 1'b0, 1'b1);   // buf_full mid frame ignored
        check(miss_count == 0, "R8", "mid-frame buf_full count", miss_count, 0);

        cur_req = "R8";
        drop_frame(15, 3);
        check(miss_count == 8'(exp_cnt), "R8", "drop count", miss_count, exp_cnt);
        check(exp_bytes.size() == 0, "R8", "drop emitted nothing", exp_bytes.size(), 0);
        send_frame(62, 1'b0, -1, 1'b0, 1'b0);

        cur_req = "R11";
        for (int i = 0; i < 4; i++) drive_nib(4'h5, 1'b0);
        drive_nib(4'h3, 1'b0);
        for (int i = 0; i < 20; i++) drive_nib(4'(i), 1'b0);
        end_frame(1'b0, 3);
        check(miss_count == 8'(exp_cnt), "R11", "bad preamble count", miss_count, exp_cnt);

        cur_req = "R9";
        while (exp_cnt < 191) drop_frame(1, 1);
        check(miss_count == 8'd191 && !miss_irq, "R9", "count 191 irq", {miss_count, miss_irq}, {8'd191, 1'b0});
        drop_frame(1, 1);
        check(miss_count == 8'd192 && miss_irq, "R9", "count 192 irq", {miss_count, miss_irq}, {8'd192, 1'b1});
        while (exp_cnt < 255) drop_frame(1, 1);
        check(miss_count == 8'd255 && miss_irq, "R9", "count 255 irq", {miss_count, miss_irq}, {8'd255, 1'b1});
        drop_frame(1, 1);
        check(miss_count == 8'd0 && !miss_irq, "R9", "wrap irq", {miss_count, miss_irq}, 0);

        cur_req = "R2"; send_frame(80, 1'b0, -1, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule